// File: doc/BRIEF.md
# Recursive Moving Average Filter

This block keeps a running total of the last `WIN` unsigned samples from a stream, and an average of them. Each accepted sample is added to an accumulator. The sample that is leaving the window is subtracted in the same update. So one update costs one addition and one subtraction, whatever the window length.

The window history is a circular buffer in a simple dual-port memory. On every accepted sample, the buffer does one write and one registered read. The read address runs one slot ahead of the write pointer. This way, the oldest entry is already on the read port when the next sample arrives.

After reset, a fill flag masks the outgoing term to zero until the buffer has wrapped once, so the buffer never has to be cleared entry by entry. The average is the sum shifted right by log2(`WIN`), which is why `WIN` must be a power of two.

Top module: `mavg_filter`

## Requirements
- R1: While `rst_ni` is low, and on the first sampling point after it, `sum_o`, `avg_o`, `valid_o` and `full_o` are all zero.
- R2: `valid_o` equals `valid_i` delayed by exactly one clock cycle.
- R3: One cycle after an accepted sample (`valid_i` high), `sum_o` equals the sum of the most recent min(k, `WIN`) accepted samples, where k is the number of samples accepted since reset.
- R4: A cycle with `valid_i` low leaves `sum_o`, `avg_o` and `full_o` unchanged. It also leaves the window contents and position unchanged, so later sums behave as if the idle cycle never happened.
- R5: `avg_o` equals `sum_o` shifted right by log2(`WIN`) bits, which is the floor of the sum divided by `WIN`.
- R6: `full_o` goes high one cycle after the `WIN`-th accepted sample since reset. It then stays high until the next reset.
- R7: `sum_o` is `DATA_W` + log2(`WIN`) bits wide and never wraps. A long run of all-ones samples settles at exactly `WIN` x (2^`DATA_W` - 1), and `avg_o` then reads 2^`DATA_W` - 1.
- R8: A reset in the middle of a stream discards the whole history. Sums after the reset count only the samples accepted after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sample strobe; high accepts `sample_i` |
| sample_i | input | DATA_W | Unsigned input sample |
| sum_o | output | DATA_W+log2(WIN) | Sum of the current window |
| avg_o | output | DATA_W | Window average (sum >> log2(WIN)) |
| valid_o | output | 1 | Output strobe, one cycle after `valid_i` |
| full_o | output | 1 | High once `WIN` samples have entered since reset |

## Verification
The bench builds the filter with `DATA_W` = 12 and `WIN` = 16, which keeps the circular buffer small. With that size, several full wraps of the write pointer, the first-full transition and the point where the subtracted term first becomes non-zero all happen within a few hundred cycles. Because the sample width is 12, the all-ones run reaches the largest possible sum, 16 x 4095, and tests the accumulator width at its exact limit. The default `WIN` of 128 and the upper value of 1024 change only the pointer and memory sizes; the datapath is the same.

// File: rtl/mavg_pkg.sv
package mavg_pkg;

  function automatic bit is_pow2(input int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int unsigned max_sum(input int unsigned data_w, input int unsigned win);
    return win * ((32'd1 << data_w) - 1);
  endfunction

endpackage

// File: rtl/mavg_ptr.sv
// Write pointer, look-ahead read address and window-full flag.
module mavg_ptr #(
  parameter int unsigned WIN = 128,
  localparam int unsigned AW = $clog2(WIN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          full_o
);

  logic [AW-1:0] wr_q;
  logic          full_q;
  logic          wrap;

  assign wrap = adv_i && (wr_q == AW'(WIN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      full_q <= 1'b0;
    end else if (adv_i) begin
      wr_q <= wr_q + AW'(1);
      if (wrap) full_q <= 1'b1;
    end
  end

  // Read one slot ahead when advancing so the oldest entry sits on the port next time.
  assign rd_addr_o = adv_i ? wr_q + AW'(1) : wr_q;
  assign wr_addr_o = wr_q;
  assign full_o    = full_q;

endmodule

// File: rtl/mavg_ram.sv
// Simple dual-port memory, registered read.
module mavg_ram #(
  parameter int unsigned DW    = 12,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/mavg_acc.sv
// Recursive accumulator: one add, one subtract per update.
module mavg_acc #(
  parameter int unsigned DW = 12,
  parameter int unsigned SW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] add_i,
  input  logic [DW-1:0] sub_i,
  input  logic          sub_en_i,
  output logic [SW-1:0] sum_o
);

  logic [SW-1:0] sum_q;
  logic [DW-1:0] sub_m;
  logic [SW-1:0] sum_d;

  assign sub_m = sub_en_i ? sub_i : '0;
  assign sum_d = sum_q + SW'(add_i) - SW'(sub_m);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_q <= '0;
    else if (en_i) sum_q <= sum_d;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/mavg_filter.sv
module mavg_filter
  import mavg_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned WIN    = 128,
  localparam int unsigned LOG_W = $clog2(WIN),
  localparam int unsigned SUM_W = DATA_W + LOG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [SUM_W-1:0]  sum_o,
  output logic [DATA_W-1:0] avg_o,
  output logic              valid_o,
  output logic              full_o
);

  if (!is_pow2(WIN)) begin : g_bad_win
    $error("WIN must be a power of two, at least 2");
  end

  logic [LOG_W-1:0]  wr_addr;
  logic [LOG_W-1:0]  rd_addr;
  logic [DATA_W-1:0] old_sample;
  logic              full;
  logic [SUM_W-1:0]  sum;
  logic              valid_q;

  mavg_ptr #(.WIN(WIN)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (valid_i),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr),
    .full_o    (full)
  );

  mavg_ram #(.DW(DATA_W), .DEPTH(WIN)) u_ram (
    .clk_i   (clk_i),
    .we_i    (valid_i),
    .waddr_i (wr_addr),
    .wdata_i (sample_i),
    .raddr_i (rd_addr),
    .rdata_o (old_sample)
  );

  // Outgoing term is masked until the buffer has wrapped once.
  mavg_acc #(.DW(DATA_W), .SW(SUM_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (valid_i),
    .add_i    (sample_i),
    .sub_i    (old_sample),
    .sub_en_i (full),
    .sum_o    (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign sum_o   = sum;
  assign avg_o   = sum[SUM_W-1:LOG_W];
  assign valid_o = valid_q;
  assign full_o  = full;

endmodule

// File: rtl/mavg_filter_chk.sv
module mavg_filter_chk
  import mavg_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned WIN    = 128,
  localparam int unsigned LOG_W = $clog2(WIN),
  localparam int unsigned SUM_W = DATA_W + LOG_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] sample_i,
  input logic [SUM_W-1:0]  sum_o,
  input logic [DATA_W-1:0] avg_o,
  input logic              valid_o,
  input logic              full_o
);

  localparam logic [SUM_W:0] MAX_SUM = (SUM_W + 1)'(max_sum(DATA_W, WIN));
  localparam logic [SUM_W:0] MAX_IN  = (SUM_W + 1)'((32'd1 << DATA_W) - 1);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (valid_o == $past(valid_i)));  // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(valid_i)) |-> ($stable(sum_o) && $stable(full_o)));  // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, sum_o} <= MAX_SUM);  // R7

  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && valid_o) |-> ({1'b0, sum_o} <= {1'b0, $past(sum_o)} + MAX_IN));  // R3

  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(full_o)) |-> full_o);  // R6

  AST_AVG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_o < SUM_W'(WIN)) |-> (avg_o == '0));  // R5

  AST_RESET_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !past_ok |-> (sum_o == '0 && !valid_o && !full_o));  // R1

endmodule

bind mavg_filter mavg_filter_chk #(.DATA_W(DATA_W), .WIN(WIN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .sample_i (sample_i),
  .sum_o    (sum_o),
  .avg_o    (avg_o),
  .valid_o  (valid_o),
  .full_o   (full_o)
);

// File: tb/mavg_filter_bench.sv
`timescale 1ns/1ps
module mavg_filter_bench;

  localparam int DW  = 12;
  localparam int WIN = 16;
  localparam int LW  = $clog2(WIN);
  localparam int SW  = DW + LW;
  localparam int MAXV = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vld = 1'b0;
  logic [DW-1:0] smp = '0;
  logic [SW-1:0] sum;
  logic [DW-1:0] avg;
  logic          vo;
  logic          full;

  int n_vec = 0;
  int n_bad = 0;
  int hist [WIN];
  int hp = 0;
  int cnt = 0;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  mavg_filter #(.DATA_W(DW), .WIN(WIN)) u_mavg_filter (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .sample_i(smp),
    .sum_o(sum), .avg_o(avg), .valid_o(vo), .full_o(full)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_sum();
    int s = 0;
    for (int i = 0; i < WIN; i++) s += hist[i];
    return s;
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < WIN; i++) hist[i] = 0;
    hp = 0;
    cnt = 0;
  endfunction

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 12) & MAXV);
  endfunction

  // Called at a negedge; returns at the next negedge with outputs settled.
  task automatic step(input bit v, input int s, input string req);
    int prev_sum = int'(sum);
    vld = v;
    smp = DW'(s);
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0;
    if (v) begin
      hist[hp] = s;
      hp = (hp + 1) % WIN;
      cnt++;
    end
    check("R2", "valid_o", int'(vo), int'(v));
    if (v) check(req, "sum_o", int'(sum), ref_sum());
    else   check("R4", "sum_o held", int'(sum), prev_sum);
    check("R5", "avg_o", int'(avg), ref_sum() >> LW);
    check("R6", "full_o", int'(full), int'(cnt >= WIN));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    vld   = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    check("R1", "sum_o in reset", int'(sum), 0);
    check("R1", "valid_o in reset", int'(vo), 0);
    check("R1", "full_o in reset", int'(full), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "sum_o after reset", int'(sum), 0);
    check("R1", "avg_o after reset", int'(avg), 0);
    check("R1", "valid_o after reset", int'(vo), 0);
  endtask

  task automatic t_warmup();
    for (int i = 0; i < WIN; i++) step(1'b1, 100 * (i + 1), "R3");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 3 * WIN + 5; i++) step(1'b1, next_rand(), "R3");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 2 * WIN; i++) begin
      step(1'b1, next_rand(), "R4");
      if (i % 3 == 0) step(1'b0, next_rand(), "R4");
      if (i % 5 == 0) begin
        step(1'b0, MAXV, "R4");
        step(1'b0, 0, "R4");
      end
    end
  endtask

  task automatic t_max();
    for (int i = 0; i < 2 * WIN; i++) step(1'b1, MAXV, "R7");
    check("R7", "saturated sum", int'(sum), WIN * MAXV);
    check("R7", "saturated avg", int'(avg), MAXV);
    step(1'b1, 0, "R7");
    check("R7", "sum after one zero", int'(sum), (WIN - 1) * MAXV);
  endtask

  task automatic t_midreset();
    for (int i = 0; i < WIN / 2; i++) step(1'b1, next_rand(), "R8");
    do_reset();
    for (int i = 0; i < WIN + 3; i++) step(1'b1, 7 + i, "R8");
  endtask

  initial begin
    model_clear();
    do_reset();
    t_warmup();
    t_wrap();
    t_idle();
    t_max();
    t_midreset();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule